// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of words one way between two clock domains that have no phase or frequency relationship. The producer pushes at most one word per write-clock cycle while `full_o` is low. The consumer pops at most one word per read-clock cycle while `empty_o` is low. Neither side needs a per-word handshake, so either side can run at one word per cycle whenever its flag allows it.

Storage is a dual-port array. One port only writes and one port only reads, and each port has its own address. Each side keeps a binary position counter that is one bit wider than the address. The counter is turned into Gray code by XOR of each pair of adjacent bits, and only that Gray value is passed through a two-flop synchronizer into the other domain. The read port is combinational, so `rd_data_o` already shows the oldest stored word whenever `empty_o` is low.

Each flag is set by its own side on the same edge as the transfer that fills or drains the last slot. A flag clears only when the other side's pointer arrives through the synchronizer, so clearing lags by a few cycles.

Top module: `dc_gray_fifo`

## Requirements
- R1: After either reset, `empty_o` reads 1 and `full_o` reads 0.
- R2: Words leave on `rd_data_o` in the same order they were accepted on `wr_data_i`. While `empty_o` is 0, `rd_data_o` shows the oldest unread word.
- R3: With no reads pending, `full_o` rises on the write-clock edge that stores word number DEPTH, and not on any earlier edge.
- R4: A write attempted while `full_o` is 1 stores nothing, and the stored contents stay the same.
- R5: `empty_o` rises on the read-clock edge that takes the last stored word, and not on any earlier edge.
- R6: A read attempted while `empty_o` is 1 does not move the read position, so the next word written is the next word read.
- R7: After a word is written into an empty FIFO, `empty_o` stays 1 at least through the first read-clock edge after the write. It falls within 8 read-clock cycles.
- R8: After a read from a full FIFO, `full_o` stays 1 immediately after the read and falls within 8 write-clock cycles.
- R9: Each stored pointer changes its Gray code in at most one bit per clock.
- R10: With `wr_en_i` or `rd_en_i` held high, one word transfers on every clock while the flag allows it. This also holds when both sides stream at the same time.
- R11: Pointer wrap-around keeps order and flag behaviour correct over several passes through the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| wr_rst_ni | input | 1 | Write-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | DW | Word to push |
| full_o | output | 1 | No free slot (write domain) |
| rd_clk_i | input | 1 | Read-domain clock |
| rd_rst_ni | input | 1 | Read-domain asynchronous reset, active low |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | DW | Oldest stored word |
| empty_o | output | 1 | Nothing stored (read domain) |

## Verification
The bench fills the array back to back and checks `full_o` edge by edge. A comparison that is off by one, or that inverts too few MSBs, would raise the flag one word early or late, or never raise it. It also pushes into a full array and pops from an empty one. A pointer that moved on those attempts would overwrite the oldest word, or replay stale data ahead of the next real word. Flag release is checked as both late enough and bounded, because a synchronizer bypass would release it too early and a missing pointer update would hang it. A concurrent streaming run across several wraps catches Gray or wrap errors that would reorder or drop words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DEF_DEPTH   = 16;
  localparam int unsigned DEF_DW      = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = dcf_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   gray_o,
  output logic          full_o
);
  logic [AW:0] bin_q, bin_d, gray_q, gray_d, full_match;
  logic        full_q;

  assign we_o   = en_i & ~full_q;
  assign bin_d  = bin_q + {{AW{1'b0}}, we_o};
  assign gray_d = bin_d ^ (bin_d >> 1);
  // full: top two Gray bits inverted, rest equal
  assign full_match = {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      full_q <= (gray_d == full_match);
    end
  end

  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;
  assign full_o = full_q;

  p_gray_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && en_i) |=> $stable(gray_o));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW:0]   wgray_sync_i,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   gray_o,
  output logic          empty_o
);
  logic [AW:0] bin_q, bin_d, gray_q, gray_d;
  logic        empty_q, pop;

  assign pop    = en_i & ~empty_q;
  assign bin_d  = bin_q + {{AW{1'b0}}, pop};
  assign gray_d = bin_d ^ (bin_d >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q   <= '0;
      gray_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      empty_q <= (gray_d == wgray_sync_i);
    end
  end

  assign addr_o  = bin_q[AW-1:0];
  assign gray_o  = gray_q;
  assign empty_o = empty_q;

  p_gray_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && en_i) |=> $stable(gray_o));
endmodule

// File: rtl/dc_gray_fifo.sv
module dc_gray_fifo #(
  parameter int unsigned DEPTH = dcf_pkg::DEF_DEPTH,
  parameter int unsigned DW    = dcf_pkg::DEF_DW,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wr_clk_i,
  input  logic          wr_rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          rd_clk_i,
  input  logic          rd_rst_ni,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o
);
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .en_i(wr_en_i),
    .rgray_sync_i(rgray_ws), .we_o(we), .addr_o(waddr),
    .gray_o(wgray), .full_o(full_o)
  );

  dcf_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .en_i(rd_en_i),
    .wgray_sync_i(wgray_rs), .addr_o(raddr),
    .gray_o(rgray), .empty_o(empty_o)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/dc_gray_fifo_bench.sv
module dc_gray_fifo_bench;
  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0, full, empty;
  logic [DW-1:0] wr_data = '0, rd_data;
  int n_run = 0, n_fail = 0;
  logic [DW-1:0] model [$];

  always #4    wclk = ~wclk;   // 125 MHz
  always #5.5  rclk = ~rclk;

  dc_gray_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dc_gray_fifo (
    .wr_clk_i(wclk), .wr_rst_ni(wrst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .rd_clk_i(rclk), .rd_rst_ni(rrst_n), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
  endtask

  // back-to-back writes, full checked after each edge
  task automatic burst_write(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wr_en = 1; wr_data = base + DW'(i);
      @(posedge wclk); #1;
      if (model.size() < DEPTH) model.push_back(base + DW'(i));
      check(full == (model.size() == DEPTH), "R3", full, model.size() == DEPTH);
    end
    @(negedge wclk); wr_en = 0;
  endtask

  // back-to-back reads, data and empty checked every cycle
  task automatic burst_read(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] exp_d;
      @(negedge rclk);
      exp_d = model.pop_front();
      check(rd_data == exp_d, "R2", rd_data, exp_d);
      rd_en = 1;
      @(posedge rclk); #1;
      check(empty == (model.size() == 0), "R5", empty, model.size() == 0);
    end
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic t_reset();
    check(empty == 1, "R1 empty", empty, 1);
    check(full == 0, "R1 full", full, 0);
  endtask

  task automatic t_latency_r7();
    int waited = 0;
    @(negedge wclk); wr_en = 1; wr_data = 8'hA1;
    @(posedge wclk); #1; wr_en = 0; model.push_back(8'hA1);
    check(empty == 1, "R7 right after write", empty, 1);
    @(posedge rclk); #1;
    check(empty == 1, "R7 first read edge", empty, 1);
    while (empty && waited < 8) begin @(posedge rclk); #1; waited++; end
    check(empty == 0, "R7 release", empty, 0);
    settle();
    burst_read(1);
  endtask

  task automatic t_fill_r3_r4_r8();
    int waited = 0;
    burst_write(DEPTH, 8'h10);
    // writes while full are dropped (R4)
    @(negedge wclk); wr_en = 1; wr_data = 8'hEE;
    repeat (3) @(posedge wclk);
    #1; check(full == 1, "R4 still full", full, 1);
    @(negedge wclk); wr_en = 0;
    settle();
    burst_read(1);
    #1; check(full == 1, "R8 held after read", full, 1);
    while (full && waited < 8) begin @(posedge wclk); #1; waited++; end
    check(full == 0, "R8 release", full, 0);
    settle();
    burst_read(DEPTH - 1);   // R4: no 0xEE may appear
    check(model.size() == 0, "R4 count", model.size(), 0);
  endtask

  task automatic t_underflow_r6();
    int waited = 0;
    @(negedge rclk); rd_en = 1;
    repeat (3) @(posedge rclk);
    @(negedge rclk); rd_en = 0;
    #1; check(empty == 1, "R6 stays empty", empty, 1);
    @(negedge wclk); wr_en = 1; wr_data = 8'h5A;
    @(negedge wclk); wr_en = 0; model.push_back(8'h5A);
    while (empty && waited < 10) begin @(posedge rclk); #1; waited++; end
    @(negedge rclk);
    check(rd_data == 8'h5A, "R6 next word", rd_data, 8'h5A);
    burst_read(1);
  endtask

  task automatic t_wrap_r11();
    for (int p = 0; p < 3; p++) begin
      burst_write(DEPTH, DW'(8'h40 + p * 16));
      settle();
      burst_read(DEPTH);
      settle();
    end
    check(empty == 1, "R11 empty after passes", empty, 1);
  endtask

  task automatic t_stream_r10();
    localparam int N = 40;
    int got = 0;
    fork
      begin
        int sent = 0;
        while (sent < N) begin
          @(negedge wclk);
          if (!full) begin wr_en = 1; wr_data = 8'h80 + DW'(sent); sent++; end
          else wr_en = 0;
        end
        @(negedge wclk); wr_en = 0;
      end
      begin
        int guard = 0;
        while (got < N && guard < 2000) begin
          @(negedge rclk); guard++;
          if (!empty) begin
            check(rd_data == 8'h80 + DW'(got), "R10 stream order", rd_data, 8'h80 + got);
            rd_en = 1; got++;
          end else rd_en = 0;
        end
        @(negedge rclk); rd_en = 0;
      end
    join
    check(got == N, "R10 stream count", got, N);
    settle();
    check(empty == 1, "R10 drained", empty, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20; wrst_n = 1; rrst_n = 1;
    settle();
    t_reset();
    t_latency_r7();
    settle();
    t_fill_r3_r4_r8();
    settle();
    t_underflow_r6();
    settle();
    t_wrap_r11();
    t_stream_r10();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule